// File: doc/BRIEF.md
# Sleep-Aware Pipelined RAM Port

This block is a synchronous single-port memory with a sleep input. A read can pass through up to two optional output register stages, each switched in by its own parameter. The first is a data output stage. The second is a post-correction stage; it models only the timing and does no correction. Depending on which stages are present, the read latency is one, two or three clock cycles from the edge that samples the address.

The sleep input takes priority over the port enable. While sleep is high, enabled writes and reads are discarded and the array is left untouched. Each output stage then clears or holds according to its own rule.

One corner case needs care. A read can be accepted in the cycle just before sleep rises while the data output stage is present. That read still accesses the array and still pulses the read-access strobe, but its data is dropped, and the port presents zero instead of the previous result.

Top module: `sleepy_ram_port`

## Requirements
- R1: When `en`=1, `we`=1 and `sleep`=0 at a clock edge, `wdata` is written to word `addr`. A later enabled read of that word returns the stored value.
- R2: A write presented while `sleep`=1 is discarded. The addressed word keeps its earlier contents, as a read after wake-up shows.
- R3: A read presented while `sleep`=1 performs no array access, and `rd_strobe` is 0 in the following cycle.
- R4: With both output stages absent, `rdata` is all zeros in every cycle after an edge at which `sleep` was sampled high.
- R5: `rd_strobe` is a registered pulse. It is 1 for the single cycle after each edge with `en`=1, `we`=0 and `sleep`=0, and 0 otherwise.
- R6: With only the post-correction stage present, `rdata` keeps the last read result while `sleep` is high. This holds except that a read accepted just before sleep still delivers its data.
- R7: With the data output stage present, a read accepted in the cycle before `sleep` rises still pulses `rd_strobe`, but its data is dropped and `rdata` becomes zero. This holds with or without the post-correction stage.
- R8: Read latency from the address-sampling edge to `rdata` is 1 + `DATA_REG` + `POST_REG` cycles.
- R9: A synchronous reset (`rst`=1) clears `rdata` and `rd_strobe` to zero. Memory contents are not reset.
- R10: After `sleep` falls, the next enabled read or write behaves normally.
- R11: With the data output stage present, that stage is zero after every edge with `sleep` sampled high. When the post-correction stage follows it, `rdata` holds its value unless it is receiving a dropped read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Port enable |
| we | input | 1 | Write enable (0 = read) |
| sleep | input | 1 | Sleep request, overrides `en` |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data after the selected stages |
| rd_strobe | output | 1 | One-cycle pulse marking an array read |

## Verification
A corrupted array word surfaces on the first read of that word after the fault, 1 to 3 cycles after its address is sampled. A stage that wrongly holds instead of clearing shows a stale non-zero `rdata` on the first cycle after sleep is sampled. A stage that clears when it should hold shows a zero where the last result belongs. A read-access flag that leaks through sleep shows as `rd_strobe` high on the very next cycle. The bench runs all four stage combinations side by side against one behavioural model, so a configuration-specific mistake is seen as a divergence in the cycle where it occurs.

// File: rtl/sleepy_ram_pkg.sv
package sleepy_ram_pkg;

   typedef enum logic [1:0] {
      PIPE_BARE  = 2'b00,
      PIPE_POST  = 2'b01,
      PIPE_DATA  = 2'b10,
      PIPE_BOTH  = 2'b11
   } pipe_kind_e;

   function automatic pipe_kind_e pipe_kind(input int data_reg, input int post_reg);
      logic [1:0] k;
      k = {data_reg != 0, post_reg != 0};
      return pipe_kind_e'(k);
   endfunction

   function automatic int read_latency(input int data_reg, input int post_reg);
      return 1 + ((data_reg != 0) ? 1 : 0) + ((post_reg != 0) ? 1 : 0);
   endfunction

endpackage

// File: rtl/sleepy_ram_array.sv
module sleepy_ram_array #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 5,
   parameter int CLEAR_SLEEP = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              we,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] arr_q,
   output logic              arr_fire
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              wr_go;
   logic              rd_go;

   assign wr_go = en & we & ~sleep;
   assign rd_go = en & ~we & ~sleep;

   always_ff @(posedge clk) begin
      if (wr_go) begin
         mem[addr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         arr_q    <= '0;
         arr_fire <= 1'b0;
      end else begin
         arr_fire <= rd_go;
         if (rd_go) begin
            arr_q <= mem[addr];
         end else if (CLEAR_SLEEP != 0 && sleep) begin
            arr_q <= '0;
         end
      end
   end

   AST_SLEEP_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
      sleep |=> mem[$past(addr)] == $past(mem[addr])); // R2

   AST_SLEEP_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
      sleep |=> !arr_fire); // R3

   AST_FIRE_ON_READ: assert property (@(posedge clk) disable iff (rst)
      (en && !we && !sleep) |=> arr_fire); // R5

   AST_HOLD_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
      (!en && !sleep) |=> $stable(arr_q)); // R5

endmodule

// File: rtl/sleepy_ram_stage.sv
module sleepy_ram_stage #(
   parameter int DATA_W        = 16,
   parameter int LOSE_ON_SLEEP = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sleep,
   input  logic [DATA_W-1:0] d_in,
   input  logic              v_in,
   output logic [DATA_W-1:0] q,
   output logic              v_out
);
   generate
      if (LOSE_ON_SLEEP != 0) begin : g_lose
         always_ff @(posedge clk) begin
            if (rst) begin
               q     <= '0;
               v_out <= 1'b0;
            end else begin
               v_out <= v_in;
               if (sleep) begin
                  q <= '0;
               end else if (v_in) begin
                  q <= d_in;
               end
            end
         end

         AST_STAGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            sleep |=> q == '0); // R11

         AST_STAGE_LOSES_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
            (v_in && sleep) |=> (v_out && q == '0)); // R7
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (rst) begin
               q     <= '0;
               v_out <= 1'b0;
            end else begin
               v_out <= v_in;
               if (v_in) begin
                  q <= d_in;
               end
            end
         end

         AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !v_in |=> $stable(q)); // R6
      end
   endgenerate

endmodule

// File: rtl/sleepy_ram_port.sv
module sleepy_ram_port #(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int DATA_REG = 1,
   parameter int POST_REG = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              we,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_strobe
);
   import sleepy_ram_pkg::*;

   localparam pipe_kind_e KIND    = pipe_kind(DATA_REG, POST_REG);
   localparam int         LATENCY = read_latency(DATA_REG, POST_REG);
   localparam int         BARE    = (KIND == PIPE_BARE) ? 1 : 0;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie in 1..12");
      end
      if (DATA_REG < 0 || DATA_REG > 1 || POST_REG < 0 || POST_REG > 1) begin : g_bad_opt
         $error("stage options must be 0 or 1");
      end
      if (LATENCY < 1 || LATENCY > 3) begin : g_bad_lat
         $error("read latency out of range");
      end
   endgenerate

   logic [DATA_W-1:0] arr_q;
   logic              arr_fire;
   logic [DATA_W-1:0] s1_q;
   logic              s1_v;
   logic [DATA_W-1:0] s2_q;
   logic              s2_v;

   sleepy_ram_array #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .CLEAR_SLEEP (BARE)
   ) u_array (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .we       (we),
      .sleep    (sleep),
      .addr     (addr),
      .wdata    (wdata),
      .arr_q    (arr_q),
      .arr_fire (arr_fire)
   );

   generate
      if (DATA_REG != 0) begin : g_data_stage
         sleepy_ram_stage #(
            .DATA_W        (DATA_W),
            .LOSE_ON_SLEEP (1)
         ) u_data_stage (
            .clk   (clk),
            .rst   (rst),
            .sleep (sleep),
            .d_in  (arr_q),
            .v_in  (arr_fire),
            .q     (s1_q),
            .v_out (s1_v)
         );
      end else begin : g_data_pass
         assign s1_q = arr_q;
         assign s1_v = arr_fire;
      end

      if (POST_REG != 0) begin : g_post_stage
         sleepy_ram_stage #(
            .DATA_W        (DATA_W),
            .LOSE_ON_SLEEP (0)
         ) u_post_stage (
            .clk   (clk),
            .rst   (rst),
            .sleep (sleep),
            .d_in  (s1_q),
            .v_in  (s1_v),
            .q     (s2_q),
            .v_out (s2_v)
         );
      end else begin : g_post_pass
         assign s2_q = s1_q;
         assign s2_v = s1_v;
      end
   endgenerate

   assign rdata     = s2_q;
   assign rd_strobe = arr_fire;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (rdata == '0 && !rd_strobe)); // R9

   generate
      if (KIND == PIPE_BARE) begin : g_chk_bare
         AST_BARE_ZERO_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
            sleep |=> rdata == '0); // R4
      end
      if (KIND == PIPE_POST) begin : g_chk_post
         AST_POST_HOLDS_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
            (sleep && !rd_strobe) |=> $stable(rdata)); // R6
      end
      if (KIND == PIPE_DATA) begin : g_chk_data
         AST_DATA_LOST_ON_SLEEP: assert property (@(posedge clk) disable iff (rst)
            (rd_strobe && sleep) |=> rdata == '0); // R7
      end
      if (KIND == PIPE_BOTH) begin : g_chk_both
         AST_BOTH_LOST_ON_SLEEP: assert property (@(posedge clk) disable iff (rst)
            (rd_strobe && sleep) |=> ##1 rdata == '0); // R7
      end
   endgenerate

endmodule

// File: tb/sleepy_ram_port_bench.sv
`timescale 1ns/1ps
module sleepy_ram_port_bench;
   localparam int DW    = 16;
   localparam int AW    = 5;
   localparam int NCFG  = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en = 1'b0;
   logic          we = 1'b0;
   logic          sleep = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;

   logic [DW-1:0] rdata_w [NCFG];
   logic          strb_w  [NCFG];

   int    errors = 0;
   int    checks = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string lbl_now = "R9";

   always #10 clk = ~clk;

   for (genvar i = 0; i < NCFG; i++) begin : g_cfg
      sleepy_ram_port #(
         .DATA_W   (DW),
         .ADDR_W   (AW),
         .DATA_REG (i / 2),
         .POST_REG (i % 2)
      ) u_sleepy_ram_port (
         .clk       (clk),
         .rst       (rst),
         .en        (en),
         .we        (we),
         .sleep     (sleep),
         .addr      (addr),
         .wdata     (wdata),
         .rdata     (rdata_w[i]),
         .rd_strobe (strb_w[i])
      );
   end

   // Behavioural reference: one memory, per-configuration pipeline words.
   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] ref_lat [NCFG];
   logic [DW-1:0] ref_s1  [NCFG];
   logic          ref_v1  [NCFG];
   logic [DW-1:0] ref_s2  [NCFG];
   logic          ref_strb;

   always @(posedge clk) begin
      bit rd;
      rd = en && !we && !sleep;
      if (rst) begin
         for (int c = 0; c < NCFG; c++) begin
            ref_lat[c] = '0; ref_s1[c] = '0; ref_v1[c] = 1'b0; ref_s2[c] = '0;
         end
         ref_strb = 1'b0;
      end else begin
         for (int c = 0; c < NCFG; c++) begin
            bit            has_d, has_p;
            logic [DW-1:0] up_d;
            logic          up_v;
            has_d = (c / 2) != 0;
            has_p = (c % 2) != 0;
            up_d = has_d ? ref_s1[c] : ref_lat[c];
            up_v = has_d ? ref_v1[c] : ref_strb;
            if (up_v) ref_s2[c] = up_d;
            if (sleep) ref_s1[c] = '0;
            else if (ref_strb) ref_s1[c] = ref_lat[c];
            ref_v1[c] = ref_strb;
            if (rd) ref_lat[c] = ref_mem[addr];
            else if (!has_d && !has_p && sleep) ref_lat[c] = '0;
         end
         ref_strb = rd;
         if (en && we && !sleep) ref_mem[addr] = wdata;
      end
   end

   function automatic logic [DW-1:0] expect_rdata(int c);
      if ((c % 2) != 0) return ref_s2[c];
      if ((c / 2) != 0) return ref_s1[c];
      return ref_lat[c];
   endfunction

   task automatic compare_all(string req);
      for (int c = 0; c < NCFG; c++) begin
         checks++;
         if (rdata_w[c] !== expect_rdata(c)) begin
            errors++;
            $display("FAIL %s cfg=%0d rdata actual=%h expected=%h", req, c, rdata_w[c], expect_rdata(c));
         end
         checks++;
         if (strb_w[c] !== ref_strb) begin
            errors++;
            $display("FAIL %s cfg=%0d rd_strobe actual=%b expected=%b", req, c, strb_w[c], ref_strb);
         end
      end
   endtask

   task automatic step(input logic e, input logic w, input logic s,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
      @(negedge clk);
      compare_all(lbl_now);
      en = e; we = w; sleep = s; addr = a; wdata = d;
      lbl_now = req;
   endtask

   task automatic direct(input bit ok, input string msg, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", msg, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      for (int c = 0; c < NCFG; c++)
         direct(rdata_w[c] == '0 && strb_w[c] == 1'b0, "R9 reset clears outputs", rdata_w[c], '0);
      rst = 1'b0;
      for (int i = 0; i < 16; i++) step(1, 1, 0, AW'(i), DW'(16'hA000 + i * 16'h0111), "R1");
      for (int i = 0; i < 16; i++) step(1, 0, 0, AW'(i), '0, "R8");
      step(0, 0, 0, '0, '0, "R8");
      step(0, 0, 0, '0, '0, "R8");
      // sleep with write attempt and read attempt
      step(1, 1, 1, 5'd3, 16'hFFFF, "R2");
      @(negedge clk);
      direct(strb_w[0] == 1'b0, "R3 strobe low in sleep", DW'(strb_w[0]), '0);
      direct(rdata_w[0] == '0, "R4 bare output zero in sleep", rdata_w[0], '0);
      compare_all(lbl_now);
      en = 1; we = 0; sleep = 1; addr = 5'd7; lbl_now = "R3";
      step(1, 0, 1, 5'd8, '0, "R6");
      step(0, 0, 1, '0, '0, "R11");
      step(0, 0, 1, '0, '0, "R4");
      // wake and read the word the sleeping write targeted
      step(1, 0, 0, 5'd3, '0, "R10");
      step(0, 0, 0, '0, '0, "R2");
      step(0, 0, 0, '0, '0, "R2");
      step(0, 0, 0, '0, '0, "R2");
      direct(rdata_w[3] == DW'(16'hA000 + 3 * 16'h0111), "R2 word kept after sleep write", rdata_w[3], DW'(16'hA000 + 3 * 16'h0111));
      // read immediately followed by sleep
      step(1, 0, 0, 5'd5, '0, "R7");
      step(1, 0, 1, 5'd6, '0, "R7");
      @(negedge clk);
      direct(strb_w[2] == 1'b0, "R3 strobe low after sleeping read", DW'(strb_w[2]), '0);
      direct(rdata_w[2] == '0, "R7 data stage lost inflight read", rdata_w[2], '0);
      compare_all(lbl_now);
      en = 0; sleep = 1; lbl_now = "R7";
      @(negedge clk);
      direct(rdata_w[3] == '0, "R7 post stage zero after lost read", rdata_w[3], '0);
      direct(rdata_w[1] == DW'(16'hA000 + 5 * 16'h0111), "R6 post-only keeps read before sleep", rdata_w[1], DW'(16'hA000 + 5 * 16'h0111));
      compare_all(lbl_now);
      lbl_now = "R11";
      step(1, 1, 0, 5'd9, 16'h1234, "R10");
      step(1, 0, 0, 5'd9, '0, "R10");
      step(1, 0, 0, 5'd2, '0, "R7");
      step(1, 0, 1, 5'd2, '0, "R7");
      step(0, 0, 0, '0, '0, "R10");
      for (int k = 0; k < 4; k++) step(0, 0, 0, '0, '0, "R8");
      for (int k = 0; k < 600; k++) begin
         int r;
         r = $urandom_range(0, 99);
         step(r < 85, $urandom_range(0, 2) == 0, r > 70, AW'($urandom_range(0, DEPTH - 1)),
              DW'($urandom), "R5");
      end
      for (int k = 0; k < 4; k++) step(0, 0, 0, '0, '0, "R8");
      @(negedge clk);
      compare_all(lbl_now);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule